// File: doc/BRIEF.md
# External Clock Bypass Request Controller

This block decides when the root clocks of a chip may be moved onto an external clock source, and it runs the handshake that carries out the move. Two parties can ask for a switch. A lifecycle controller asks for a bypass of the I/O clock only. A software control field asks for a bypass of every clock source, and that request counts only while hardware debug is enabled. Each accepted request goes to the analog clock source as a level request. The block then waits for the matching acknowledge level.

When the switch is acknowledged, the block can tell the fixed clock dividers to step down by one power of two. A divide-by-4 output then becomes divide-by-2, and a divide-by-2 output becomes divide-by-1. The lifecycle path always steps down, and it acknowledges its requester only after the step-down is in place. The software path steps down only when its speed field selects a low-speed external clock. When a request is withdrawn, the bypass request is released first. The step-down stays until the analog side has lowered its acknowledge.

The two software fields use 4-bit redundant encodings. A code that is neither the true code nor the false code is read as false and raises an error flag. The debug-enable input and both acknowledge inputs are asynchronous and pass through two-flop synchronizers.

Top module: `clk_bypass_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, io_byp_req_o, all_byp_req_o, lc_byp_ack_o, div_step_o and mubi_err_o are all 0.
- R2: When lc_byp_req_i rises, io_byp_req_o is 1 after the next rising clock edge and stays 1 while the request is held.
- R3: io_byp_ack_i passes through two synchronizer flops. div_step_o goes to 1 on the third rising edge after the acknowledge rises. lc_byp_ack_o goes to 1 one edge later, so the step-down always comes before the lifecycle acknowledge.
- R4: all_byp_req_o is raised only when sw_sel_i holds the true code 4'b0110 and the debug enable, after its two synchronizer flops, is 1. A debug enable that rises together with the select takes effect on the third rising edge.
- R5: After all_byp_ack_i has been synchronized, div_step_o goes to 1 if sw_speed_i holds the false code 4'b1001 (low speed). It stays 0 if sw_speed_i holds the true code 4'b0110 (high speed).
- R6: While lc_byp_req_i is 1, the software select is treated as false, and all_byp_req_o stays 0.
- R7: A value on sw_sel_i or sw_speed_i other than 4'b0110 or 4'b1001 is treated as false. mubi_err_o is 1 after the next rising edge for as long as such a value is present.
- R8: When a request is withdrawn, its bypass request output and lc_byp_ack_o fall after the next rising edge. div_step_o stays 1 until the synchronized acknowledge is 0, and it falls on the third rising edge after the acknowledge input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| lc_byp_req_i | input | 1 | Lifecycle request for I/O clock bypass |
| lc_byp_ack_o | output | 1 | Acknowledge to the lifecycle requester |
| sw_sel_i | input | 4 | Software bypass select, redundant code |
| sw_speed_i | input | 4 | Software speed select, true code means high speed |
| dbg_en_i | input | 1 | Hardware debug allowed, asynchronous |
| io_byp_req_o | output | 1 | I/O-clock bypass request to the analog source |
| io_byp_ack_i | input | 1 | I/O-clock bypass acknowledge, asynchronous |
| all_byp_req_o | output | 1 | All-clocks bypass request to the analog source |
| all_byp_ack_i | input | 1 | All-clocks bypass acknowledge, asynchronous |
| div_step_o | output | 1 | Dividers step down by a factor of two |
| mubi_err_o | output | 1 | Invalid code seen on a software field |

## Verification
The assertions check the ordering rules on every cycle. The step-down never rises without a prior synchronized acknowledge, and it never falls while that acknowledge is still high. The lifecycle acknowledge never appears without the step-down. A software request never starts without debug enabled or while a lifecycle request is present. A channel with no requester never raises its bypass request. Only the bench's scenarios can show the exact cycle counts through the synchronizers, the effect of the speed code, the handling of invalid codes and the error flag, and the full release sequence.

// File: rtl/clk_bypass_pkg.sv
// Package: shared encodings and state type for the clock bypass controller.
// Assumes the software fields use a 4-bit redundant code with one true and one false value.
package clk_bypass_pkg;
    localparam int unsigned MUBI_W = 4;
    localparam logic [MUBI_W-1:0] MUBI_TRUE  = 4'b0110;
    localparam logic [MUBI_W-1:0] MUBI_FALSE = 4'b1001;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        CH_IDLE = 3'd0,
        CH_WAIT = 3'd1,
        CH_STEP = 3'd2,
        CH_DONE = 3'd3,
        CH_DROP = 3'd4
    } chan_state_e;
endpackage

// File: rtl/byp_sync.sv
// Module: multi-stage flop synchronizer for a vector of independent level signals.
// Assumes each bit is a slow level that may be sampled on any edge.
module byp_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mubi_check.sv
// Module: decodes one redundant multi-bit field into a true flag and a bad-code flag.
// Assumes any code other than the true and false codes is illegal and must be read as false.
module mubi_check
    import clk_bypass_pkg::*;
(
    input  logic [MUBI_W-1:0] val_i,
    output logic              is_true_o,
    output logic              is_bad_o
);
    // Classify the field value.
    always_comb begin
        is_true_o = (val_i == MUBI_TRUE);
        is_bad_o  = (val_i != MUBI_TRUE) && (val_i != MUBI_FALSE);
    end
endmodule

// File: rtl/byp_chan.sv
// Module: one bypass handshake channel (request, acknowledge wait, step-down, release).
// Assumes ack_i is already synchronized and that the analog side returns ack low after req falls.
module byp_chan
    import clk_bypass_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic step_en_i,
    input  logic ack_i,
    output logic byp_req_o,
    output logic step_o,
    output logic done_o
);
    chan_state_e state_q, state_d;
    logic        step_q;

    // Next-state selection for the handshake sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (req_i) state_d = CH_WAIT;
            CH_WAIT: if (!req_i) state_d = CH_DROP;
                     else if (ack_i) state_d = CH_STEP;
            CH_STEP: state_d = req_i ? CH_DONE : CH_DROP;
            CH_DONE: if (!req_i) state_d = CH_DROP;
            CH_DROP: if (!ack_i) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // State register and step-down flag, held until the acknowledge has fallen.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= CH_IDLE;
            step_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CH_WAIT && req_i && ack_i) step_q <= step_en_i;
            else if (state_q == CH_DROP && !ack_i)   step_q <= 1'b0;
        end
    end

    assign byp_req_o = (state_q == CH_WAIT) || (state_q == CH_STEP) || (state_q == CH_DONE);
    assign done_o    = (state_q == CH_DONE);
    assign step_o    = step_q;

    // R3: step-down only follows an observed acknowledge.
    a_r3_step_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(step_q) |-> $past(ack_i));
    // R8: step-down is not removed while the acknowledge is still high.
    a_r8_step_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(step_q) |-> !$past(ack_i));
    // R8: no bypass request appears without a requester.
    a_r8_no_orphan_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_i && !byp_req_o) |=> !byp_req_o);
endmodule

// File: rtl/clk_bypass_ctrl.sv
// Module: arbitrates lifecycle and software external-clock bypass requests and drives
// the divider step-down. Assumes debug enable and both acknowledges are asynchronous.
module clk_bypass_ctrl
    import clk_bypass_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lc_byp_req_i,
    output logic              lc_byp_ack_o,
    input  logic [MUBI_W-1:0] sw_sel_i,
    input  logic [MUBI_W-1:0] sw_speed_i,
    input  logic              dbg_en_i,
    output logic              io_byp_req_o,
    input  logic              io_byp_ack_i,
    output logic              all_byp_req_o,
    input  logic              all_byp_ack_i,
    output logic              div_step_o,
    output logic              mubi_err_o
);
    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] async_in, sync_out;
    logic dbg_s, io_ack_s, all_ack_s;
    logic sel_true, sel_bad, speed_true, speed_bad;
    logic sw_req, lc_step, sw_step, sw_done_unused;
    logic err_q;

    assign async_in = {dbg_en_i, all_byp_ack_i, io_byp_ack_i};

    byp_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i), .rst_ni (rst_ni), .d_i (async_in), .q_o (sync_out)
    );
    assign {dbg_s, all_ack_s, io_ack_s} = sync_out;

    mubi_check u_sel (.val_i (sw_sel_i), .is_true_o (sel_true), .is_bad_o (sel_bad));
    mubi_check u_spd (.val_i (sw_speed_i), .is_true_o (speed_true), .is_bad_o (speed_bad));

    // Software request: valid select, debug allowed, no lifecycle request present.
    assign sw_req = sel_true && dbg_s && !lc_byp_req_i;

    byp_chan u_lc (
        .clk_i (clk_i), .rst_ni (rst_ni), .req_i (lc_byp_req_i), .step_en_i (1'b1),
        .ack_i (io_ack_s), .byp_req_o (io_byp_req_o), .step_o (lc_step), .done_o (lc_byp_ack_o)
    );

    byp_chan u_sw (
        .clk_i (clk_i), .rst_ni (rst_ni), .req_i (sw_req), .step_en_i (!speed_true),
        .ack_i (all_ack_s), .byp_req_o (all_byp_req_o), .step_o (sw_step), .done_o (sw_done_unused)
    );

    assign div_step_o = lc_step || sw_step;

    // Register the invalid-code flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= sel_bad || speed_bad;
    end
    assign mubi_err_o = err_q;

    // R3: the lifecycle requester is never acknowledged before the step-down.
    a_r3_step_before_lcack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lc_byp_ack_o |-> div_step_o);
    // R4: a software bypass only starts with debug allowed.
    a_r4_sw_needs_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(all_byp_req_o) |-> $past(dbg_s));
    // R6: a lifecycle request blocks new software bypasses.
    a_r6_lc_blocks_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(all_byp_req_o) |-> !$past(lc_byp_req_i));
endmodule

// File: tb/clk_bypass_ctrl_tb.sv
`timescale 1ns/1ps
module clk_bypass_ctrl_tb;
    localparam logic [3:0] T = 4'b0110;
    localparam logic [3:0] F = 4'b1001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lc_req = 0, io_ack = 0, all_ack = 0, dbg = 0;
    logic [3:0] sel = F, spd = F;
    logic lc_ack, io_req, all_req, step, err;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    clk_bypass_ctrl u_dut (
        .clk_i (clk), .rst_ni (rst_n), .lc_byp_req_i (lc_req), .lc_byp_ack_o (lc_ack),
        .sw_sel_i (sel), .sw_speed_i (spd), .dbg_en_i (dbg), .io_byp_req_o (io_req),
        .io_byp_ack_i (io_ack), .all_byp_req_o (all_req), .all_byp_ack_i (all_ack),
        .div_step_o (step), .mubi_err_o (err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 io_req", io_req, 0); chk("R1 all_req", all_req, 0);
        chk("R1 lc_ack", lc_ack, 0); chk("R1 step", step, 0); chk("R1 err", err, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        chk("R1 step after release", step, 0); chk("R1 io_req after release", io_req, 0);
    endtask

    task automatic t_lifecycle;
        @(negedge clk) lc_req = 1;
        cyc(1); chk("R2 io_req", io_req, 1); chk("R2 lc_ack early", lc_ack, 0);
        @(negedge clk) io_ack = 1;
        cyc(2); chk("R3 step not yet", step, 0);
        cyc(1); chk("R3 step", step, 1); chk("R3 lc_ack after step", lc_ack, 0);
        cyc(1); chk("R3 lc_ack", lc_ack, 1); chk("R2 io_req held", io_req, 1);
        @(negedge clk) lc_req = 0;
        cyc(1); chk("R8 io_req drop", io_req, 0); chk("R8 lc_ack drop", lc_ack, 0);
        chk("R8 step held", step, 1);
        @(negedge clk) io_ack = 0;
        cyc(2); chk("R8 step still held", step, 1);
        cyc(1); chk("R8 step released", step, 0);
    endtask

    task automatic t_sw_gated;
        @(negedge clk) begin sel = T; dbg = 0; end
        cyc(6); chk("R4 no req without debug", all_req, 0);
        @(negedge clk) dbg = 1;
        cyc(2); chk("R4 debug sync delay", all_req, 0);
        cyc(1); chk("R4 all_req", all_req, 1);
        @(negedge clk) sel = F;
        cyc(1); chk("R8 all_req drop", all_req, 0);
        cyc(3); chk("R8 idle step", step, 0);
    endtask

    task automatic t_sw_speed(input logic hi);
        @(negedge clk) begin spd = hi ? T : F; sel = T; end
        cyc(1); chk("R4 all_req speed case", all_req, 1); chk("R6 io untouched", io_req, 0);
        @(negedge clk) all_ack = 1;
        cyc(3); chk("R5 step by speed", step, !hi);
        @(negedge clk) sel = F;
        cyc(1); chk("R8 all_req drop", all_req, 0); chk("R8 step held sw", step, !hi);
        @(negedge clk) all_ack = 0;
        cyc(3); chk("R8 sw step released", step, 0);
        spd = F;
    endtask

    task automatic t_lc_priority;
        @(negedge clk) begin lc_req = 1; sel = T; end
        cyc(5); chk("R6 sw masked", all_req, 0); chk("R6 io_req", io_req, 1);
        @(negedge clk) begin lc_req = 0; sel = F; end
        cyc(2); chk("R6 idle after", io_req, 0);
    endtask

    task automatic t_bad_codes;
        @(negedge clk) sel = 4'b0000;
        cyc(1); chk("R7 err on bad sel", err, 1);
        cyc(4); chk("R7 bad sel is false", all_req, 0);
        @(negedge clk) begin sel = T; spd = 4'b1111; end
        cyc(1); chk("R7 err on bad speed", err, 1); chk("R7 req with bad speed", all_req, 1);
        @(negedge clk) all_ack = 1;
        cyc(3); chk("R7 bad speed read as low speed", step, 1);
        @(negedge clk) begin sel = F; spd = F; end
        cyc(1); chk("R7 err clears", err, 0);
        @(negedge clk) all_ack = 0;
        cyc(3); chk("R7 final step", step, 0);
    endtask

    initial begin
        fork
            begin
                cyc(3);
                t_reset();
                t_lifecycle();
                t_sw_gated();
                t_sw_speed(1'b0);
                t_sw_speed(1'b1);
                t_lc_priority();
                t_bad_codes();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule